// File: doc/BRIEF.md
# Supervisory Reset and Watchdog Controller

This block drives a pair of processor reset outputs, one active-high and one active-low. Three things can make them active: a supply-valid flag from an external comparator, a watchdog that software must service through a strobe input, and a pushbutton that is active low. All timing is counted in millisecond ticks. A prescaler divides the free-running clock to produce these ticks. After every event, reset stays active for a fixed hold window. The window begins when the event ends.

A mode input selects how the block treats power. With the mode low, the processor is not battery backed, so a supply drop puts it straight into reset. With the mode high, the processor is battery backed. A supply drop then causes no reset. While the early-warning-low flag is set, the watchdog and the pushbutton are switched off, so a processor that is about to sleep is left alone.

The flags `supply_ok`, `early_low` and `batt_mode` must already be synchronous to `clk`. The strobe and the pushbutton may be asynchronous. Each passes through a two-flop synchronizer. There is no data stream, so every pin is a plain level.

Top module: `sup_reset_ctrl`

## Requirements
- R1: While `rst_n` is low, and for RST_HOLD_MS ticks after it is released, `cpu_rst` is 1. A reset output only deasserts in the cycle after a tick.
- R2: `cpu_rst_n` is always the exact complement of `cpu_rst`, and both come from flops.
- R3: With `batt_mode`=0, `supply_ok`=0 makes `cpu_rst` 1 at the next clock edge. Once `supply_ok` returns to 1, `cpu_rst` stays 1 for RST_HOLD_MS further ticks.
- R4: The watchdog counts ticks only while reset is inactive, `supply_ok`=1, and not (`batt_mode`=1 and `early_low`=1). When it reaches WDT_MS ticks without a strobe, reset is asserted for RST_HOLD_MS ticks. The watchdog then starts again from zero.
- R5: A 1-to-0 transition of `strobe_in`, seen after the synchronizer, clears the watchdog count. Rising edges and steady levels leave the count running.
- R6: `button_n`=0 counts as a press only after it has been stable for DEBOUNCE_MS ticks. A shorter low pulse has no effect. A press holds reset active, and the RST_HOLD_MS window starts when the debounced release occurs.
- R7: With `batt_mode`=1, `supply_ok`=0 does not assert reset.
- R8: With `batt_mode`=1 and `early_low`=1, the watchdog count is held at zero and the pushbutton is ignored.
- R9: With `supply_ok`=0, the watchdog count is held at zero in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous block reset, active low |
| supply_ok | input | 1 | Supply within tolerance (synchronous) |
| early_low | input | 1 | Early-warning sense is below its threshold (synchronous) |
| batt_mode | input | 1 | 1 = battery-backed processor, 0 = volatile processor |
| strobe_in | input | 1 | Watchdog service strobe; a falling edge is the service event |
| button_n | input | 1 | Pushbutton, active low, asynchronous |
| cpu_rst | output | 1 | Processor reset, active high |
| cpu_rst_n | output | 1 | Processor reset, active low |

## Verification
A wrong prescaler, hold or watchdog count shows at the ports as a reset edge that lands in the wrong cycle. A hold count that is off by one moves the deassertion by a whole tick period, so a comparison made on every clock catches it within one hold window. A gating term that is missing, whether the mode, the early-warning flag or the supply, shows up as a spurious reset pulse. That pulse appears one watchdog period after strobing stops, or one debounce period after a press. A synchronizer or edge detector that is wrongly wired either resets a well-serviced processor within one watchdog period, or fails to reset a neglected one.

// File: rtl/sup_pkg.sv
package sup_pkg;

  // Counter width able to hold the values 0 .. n-1 (at least one bit).
  function automatic int cnt_w(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  // Reset requests gathered in one cycle.
  typedef struct packed {
    logic supply_fail;
    logic button;
    logic wdog;
  } rst_req_t;

endpackage

// File: rtl/sup_tick.sv
module sup_tick #(
  parameter int CLKS_PER_MS = 1000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int W = sup_pkg::cnt_w(CLKS_PER_MS);
  localparam logic [W-1:0] LAST = W'(CLKS_PER_MS - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + W'(1);
  end

  assign tick = (cnt_q == LAST);
endmodule

// File: rtl/sup_sync2.sv
module sup_sync2 #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/sup_debounce.sv
module sup_debounce #(
  parameter int STABLE_TICKS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic raw,
  output logic level
);
  localparam int W = sup_pkg::cnt_w(STABLE_TICKS);
  localparam logic [W-1:0] LAST = W'(STABLE_TICKS - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level <= 1'b1;
      cnt_q <= '0;
    end else if (raw == level) begin
      cnt_q <= '0;
    end else if (tick) begin
      if (cnt_q == LAST) begin
        level <= raw;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + W'(1);
      end
    end
  end
endmodule

// File: rtl/sup_watchdog.sv
module sup_watchdog #(
  parameter int TIMEOUT_TICKS = 400,
  localparam int W = sup_pkg::cnt_w(TIMEOUT_TICKS)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         enable,
  input  logic         kick,
  output logic         expire,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] LAST = W'(TIMEOUT_TICKS - 1);

  assign expire = enable && !kick && tick && (count == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                count <= '0;
    else if (!enable || kick)  count <= '0;
    else if (tick)             count <= (count == LAST) ? '0 : count + W'(1);
  end
endmodule

// File: rtl/sup_reset_ctrl.sv
module sup_reset_ctrl #(
  parameter int CLKS_PER_MS = 1000,
  parameter int RST_HOLD_MS = 100,
  parameter int WDT_MS      = 400,
  parameter int DEBOUNCE_MS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic early_low,
  input  logic batt_mode,
  input  logic strobe_in,
  input  logic button_n,
  output logic cpu_rst,
  output logic cpu_rst_n
);
  import sup_pkg::*;

  localparam int HW  = cnt_w(RST_HOLD_MS);
  localparam int WCW = cnt_w(WDT_MS);
  localparam logic [HW-1:0] HOLD_LAST = HW'(RST_HOLD_MS - 1);

  logic           tick;
  logic           strobe_s, button_s, strobe_d, kick;
  logic           button_db;
  logic           gate_early, wdt_en, wdt_expire;
  logic [WCW-1:0] wdt_count;
  rst_req_t       req;
  logic           rst_hi_q, rst_lo_q, act_nx;
  logic [HW-1:0]  hold_count, hold_nx;

  sup_tick #(.CLKS_PER_MS(CLKS_PER_MS)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  sup_sync2 #(.W(2), .RST_VAL(2'b11)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({strobe_in, button_n}), .q({strobe_s, button_s})
  );

  // Falling-edge detect on the synchronized strobe.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_d <= 1'b1;
    else        strobe_d <= strobe_s;
  end
  assign kick = strobe_d && !strobe_s;

  generate
    if (DEBOUNCE_MS == 0) begin : g_no_deb
      assign button_db = button_s;
    end else begin : g_deb
      sup_debounce #(.STABLE_TICKS(DEBOUNCE_MS)) u_deb (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .raw(button_s), .level(button_db)
      );
    end
  endgenerate

  assign gate_early = batt_mode && early_low;
  assign wdt_en     = !rst_hi_q && supply_ok && !gate_early;

  sup_watchdog #(.TIMEOUT_TICKS(WDT_MS)) u_wdt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .enable(wdt_en),
    .kick(kick), .expire(wdt_expire), .count(wdt_count)
  );

  always_comb begin
    req.supply_fail = !supply_ok && !batt_mode;
    req.button      = !button_db && !gate_early;
    req.wdog        = wdt_expire;
  end

  // Hold window: reloaded while any request is present, then counts ticks.
  always_comb begin
    act_nx  = rst_hi_q;
    hold_nx = hold_count;
    if (|req) begin
      act_nx  = 1'b1;
      hold_nx = '0;
    end else if (rst_hi_q && tick) begin
      if (hold_count == HOLD_LAST) begin
        act_nx  = 1'b0;
        hold_nx = '0;
      end else begin
        hold_nx = hold_count + HW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_hi_q   <= 1'b1;
      rst_lo_q   <= 1'b0;
      hold_count <= '0;
    end else begin
      rst_hi_q   <= act_nx;
      rst_lo_q   <= !act_nx;
      hold_count <= hold_nx;
    end
  end

  assign cpu_rst   = rst_hi_q;
  assign cpu_rst_n = rst_lo_q;
endmodule

// File: rtl/sup_reset_chk.sv
module sup_reset_chk (
  input logic clk,
  input logic rst_n,
  input logic supply_ok,
  input logic early_low,
  input logic batt_mode,
  input logic cpu_rst,
  input logic cpu_rst_n,
  input logic tick,
  input logic wdt_clear
);
  // R2
  p_complement_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rst_n == !cpu_rst);

  // R1
  p_release_on_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_rst) |-> $past(tick));

  // R3
  p_supply_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!batt_mode && !supply_ok) |=> cpu_rst);

  // R4
  p_wdt_idle_in_reset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cpu_rst) && cpu_rst) |-> wdt_clear);

  // R7
  p_batt_no_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (batt_mode && early_low && !supply_ok && !cpu_rst) |=> !cpu_rst);

  // R8
  p_early_gates_wdt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (batt_mode && early_low) |=> wdt_clear);

  // R9
  p_supply_gates_wdt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> wdt_clear);
endmodule

bind sup_reset_ctrl sup_reset_chk u_chk (
  .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .early_low(early_low),
  .batt_mode(batt_mode), .cpu_rst(cpu_rst), .cpu_rst_n(cpu_rst_n),
  .tick(tick), .wdt_clear(wdt_count == '0)
);

// File: tb/sup_reset_ctrl_test.sv
module sup_reset_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int CPM   = 4;
  localparam int HOLD  = 5;
  localparam int WDT   = 12;
  localparam int DEB   = 3;
  localparam int LIMIT = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_ok = 1'b1, early_low = 1'b0, batt_mode = 1'b0;
  logic strobe_in = 1'b1, button_n = 1'b1;
  logic cpu_rst, cpu_rst_n;

  int checks = 0, errors = 0, cyc = 0, sc = 0;
  bit auto_strobe = 1'b0, rst_seen = 1'b0, done = 1'b0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  sup_reset_ctrl #(.CLKS_PER_MS(CPM), .RST_HOLD_MS(HOLD), .WDT_MS(WDT),
                   .DEBOUNCE_MS(DEB)) uut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .early_low(early_low),
    .batt_mode(batt_mode), .strobe_in(strobe_in), .button_n(button_n),
    .cpu_rst(cpu_rst), .cpu_rst_n(cpu_rst_n)
  );

  // Behavioural reference, stepped on every rising edge.
  int m_pres, m_dbc, m_wdt, m_hold;
  bit m_s1, m_s2, m_sd, m_b1, m_b2, m_db, m_act;

  always @(posedge clk or negedge rst_n) begin : model
    bit tk, fall, gate, press, wen, expire, trig, n_act, n_db;
    int n_hold, n_wdt, n_dbc;
    if (!rst_n) begin
      m_pres = 0; m_dbc = 0; m_wdt = 0; m_hold = 0;
      m_s1 = 1; m_s2 = 1; m_sd = 1; m_b1 = 1; m_b2 = 1; m_db = 1; m_act = 1;
    end else begin
      tk     = (m_pres == CPM - 1);
      fall   = m_sd && !m_s2;
      gate   = batt_mode && early_low;
      press  = !m_db && !gate;
      wen    = !m_act && supply_ok && !gate;
      expire = wen && !fall && tk && (m_wdt == WDT - 1);
      trig   = (!supply_ok && !batt_mode) || press || expire;
      n_act = m_act; n_hold = m_hold;
      if (trig) begin n_act = 1; n_hold = 0; end
      else if (m_act && tk) begin
        if (m_hold == HOLD - 1) begin n_act = 0; n_hold = 0; end
        else n_hold = m_hold + 1;
      end
      if (!wen || fall) n_wdt = 0;
      else if (tk) n_wdt = (m_wdt == WDT - 1) ? 0 : m_wdt + 1;
      else n_wdt = m_wdt;
      n_db = m_db; n_dbc = m_dbc;
      if (m_b2 == m_db) n_dbc = 0;
      else if (tk) begin
        if (m_dbc == DEB - 1) begin n_db = m_b2; n_dbc = 0; end
        else n_dbc = m_dbc + 1;
      end
      m_sd = m_s2; m_s2 = m_s1; m_s1 = strobe_in;
      m_b2 = m_b1; m_b1 = button_n;
      m_pres = tk ? 0 : m_pres + 1;
      m_act = n_act; m_hold = n_hold; m_wdt = n_wdt; m_db = n_db; m_dbc = n_dbc;
    end
  end

  // Per-cycle comparison away from the active edge.
  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (cpu_rst !== m_act || cpu_rst_n !== !m_act) begin
        errors++;
        $display("FAIL %s: cpu_rst=%0b cpu_rst_n=%0b expected %0b/%0b at cycle %0d",
                 cur_req, cpu_rst, cpu_rst_n, m_act, !m_act, cyc);
      end
      if (rst_n && cpu_rst) rst_seen = 1'b1;
    end
  end

  always @(negedge clk) begin
    if (auto_strobe) begin
      sc++;
      if (sc % 8 == 0) strobe_in <= ~strobe_in;
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == LIMIT && !done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not end, actual cycle %0d expected below %0d", cyc, LIMIT);
      finish_run();
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  initial begin
    wait_cyc(4);
    chk("R1 reset state cpu_rst", cpu_rst, 1'b1);
    chk("R2 reset state cpu_rst_n", cpu_rst_n, 1'b0);
    rst_n = 1'b1;
    wait_cyc(2);
    chk("R1 held after release", cpu_rst, 1'b1);
    auto_strobe = 1'b1;
    wait_cyc(30);
    chk("R1 released after hold", cpu_rst, 1'b0);

    cur_req = "R5"; rst_seen = 0;
    wait_cyc(200);
    chk("R5 regular strobing prevents reset", rst_seen, 1'b0);

    cur_req = "R4"; auto_strobe = 0; strobe_in = 1'b1; rst_seen = 0;
    wait_cyc(70);
    chk("R4 watchdog reset with strobe static", rst_seen, 1'b1);
    wait_cyc(60);
    auto_strobe = 1'b1;
    wait_cyc(60);
    chk("R4 serviced after restart", cpu_rst, 1'b0);

    cur_req = "R3"; supply_ok = 1'b0;
    wait_cyc(30);
    chk("R3 supply drop asserts reset", cpu_rst, 1'b1);
    supply_ok = 1'b1;
    wait_cyc(10);
    chk("R3 still held after recovery", cpu_rst, 1'b1);
    wait_cyc(30);
    chk("R3 released after hold", cpu_rst, 1'b0);

    cur_req = "R7"; batt_mode = 1'b1; auto_strobe = 0; supply_ok = 1'b0; rst_seen = 0;
    wait_cyc(120);
    chk("R7 R9 battery supply drop no reset, watchdog idle", rst_seen, 1'b0);
    auto_strobe = 1'b1; supply_ok = 1'b1;
    wait_cyc(20);
    batt_mode = 1'b0;
    wait_cyc(20);

    cur_req = "R6"; rst_seen = 0; button_n = 1'b0;
    wait_cyc(6);
    button_n = 1'b1;
    wait_cyc(30);
    chk("R6 short press ignored", rst_seen, 1'b0);
    button_n = 1'b0;
    wait_cyc(40);
    chk("R6 debounced press asserts reset", cpu_rst, 1'b1);
    button_n = 1'b1;
    wait_cyc(10);
    chk("R6 hold runs from release", cpu_rst, 1'b1);
    wait_cyc(60);
    chk("R6 released after hold", cpu_rst, 1'b0);

    cur_req = "R8"; batt_mode = 1'b1; early_low = 1'b1; auto_strobe = 0; rst_seen = 0;
    wait_cyc(120);
    chk("R8 watchdog gated by early warning", rst_seen, 1'b0);
    button_n = 1'b0;
    wait_cyc(40);
    button_n = 1'b1;
    wait_cyc(30);
    chk("R8 pushbutton ignored under early warning", rst_seen, 1'b0);
    auto_strobe = 1'b1; early_low = 1'b0;
    wait_cyc(40);
    chk("R8 normal after early warning clears", cpu_rst, 1'b0);

    finish_run();
  end
endmodule